// File: doc/BRIEF.md
# SPI NOR Memory-Window Read Engine

This block puts a serial NOR flash behind a read-only memory window. A bus master issues a word read with a window offset on a valid/ready request port. If that offset lies inside the line the engine holds, the word comes back at once. If it does not, the engine runs one complete single-lane flash read transaction and fills its line buffer from it. That transaction is an optional command byte, an optional address, an optional run of dummy clocks, and then the line's data bytes. The engine then answers from the newly filled line.

A small configuration port sets the transaction. Register 0 selects window mode, where reads are served, or manual mode, where they are not. Register 1 holds the command byte, the command enable, the address-phase mask and the dummy enable. Register 2 holds the dummy count. Register 3 holds the line-buffer flush, the burst enable and the burst length. Any change to the transaction format throws the buffered line away.

Both data ports follow valid/ready rules. A request is taken on a clock edge where `rd_valid` and `rd_ready` are both high. `rd_ready` is high only when the engine is idle in window mode and has no response waiting. A response is offered with `resp_valid`. It stays offered with unchanged `resp_data` until the master raises `resp_ready`. The master can therefore stall the engine for any number of cycles without losing data.

Top module: `flash_window_reader`

## Requirements
- R1: After reset `rd_ready` and `resp_valid` are 0, `spi_cs_n` is 1 and `spi_sck` is 0.
- R2: Requests are accepted only while register 0 bit 0 is 1 (window mode). With that bit 0, `rd_ready` stays low, no response appears and chip select stays high.
- R3: A miss drives `spi_cs_n` low for one transaction, sent MSB first in SPI mode 0. When register 1 bit 8 is 1, the transaction opens with the command byte in register 1 bits 7:0. When bit 8 is 0, no command bits are sent.
- R4: When register 1 bits 12:9 equal 4'b0111, a 24-bit address follows the command. It is the access offset rounded down to an 8-byte boundary. Any other mask value sends no address, and the line is then filled from flash address 0.
- R5: When register 1 bit 13 is 1, N+1 dummy clocks with MOSI low follow the address, where N is register 2 bits 3:0. When bit 13 is 0, no dummy clocks are sent.
- R6: With register 3 bit 1 clear, a miss fetches 8 data bytes. With it set, a miss fetches (L+1)*8 bytes, where L is register 3 bits 6:2.
- R7: `resp_data` holds the four bytes at the word-aligned offset in little-endian order, with the lowest address in bits 7:0. Offset bits 1:0 are ignored.
- R8: An accepted request whose offset lies inside the valid buffered line raises `resp_valid` in the next cycle, and `spi_cs_n` stays high. An offset outside the line causes a new transaction.
- R9: Writing register 3 with bit 0 set invalidates the line, so the next read is a miss. Writing register 3 with bit 0 clear leaves the line valid.
- R10: Any write to register 1 or register 2 invalidates the line.
- R11: While `resp_valid` is high and `resp_ready` is low, `resp_valid` and `resp_data` hold their values and `rd_ready` stays low.
- R12: `spi_sck` runs at half the clock rate during a transaction and is low whenever `spi_cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration register select (0..3) |
| cfg_wdata | input | 14 | Configuration write data |
| rd_valid | input | 1 | Read request valid |
| rd_ready | output | 1 | Read request ready |
| rd_addr | input | AW (24) | Window byte offset of the request |
| resp_valid | output | 1 | Read response valid |
| resp_ready | input | 1 | Read response ready |
| resp_data | output | 32 | Read response word |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Flash serial clock |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
Reads are driven against a serial flash model in the bench. The model records every header bit it receives and returns a data pattern that is a function of the address. The model is run with four header formats: command and address, command, address and dummy clocks, address only, and command only. Each format changes the bit count in its own way and shifts where the data starts, so a missing or extra phase shows up as a wrong header word or wrong data. A run of reads covers the same unit, a neighbouring unit, an unaligned offset and every word of a burst line. These separate hits from misses and check the line-boundary compare and the byte order. A response back-pressure pattern during the burst hits checks that responses are held.

// File: rtl/fwr_pkg.sv
package fwr_pkg;

  localparam int FWR_CMD_W = 8;
  localparam int FWR_DMY_W = 4;
  localparam int FWR_BL_W  = 5;
  localparam int FWR_CFG_DW = 14;

  localparam logic [1:0] SEL_MODE  = 2'd0;
  localparam logic [1:0] SEL_CMD   = 2'd1;
  localparam logic [1:0] SEL_DMY   = 2'd2;
  localparam logic [1:0] SEL_CACHE = 2'd3;

  localparam logic [3:0] ADDR_MASK_3B = 4'b0111;

  typedef struct packed {
    logic                 win_mode;
    logic [FWR_CMD_W-1:0] cmd;
    logic                 cmd_en;
    logic [3:0]           addr_mask;
    logic                 dmy_en;
    logic [FWR_DMY_W-1:0] dmy_n;
    logic                 burst_en;
    logic [FWR_BL_W-1:0]  burst_len;
  } fwr_cfg_t;

  typedef enum logic [2:0] {
    PH_IDLE, PH_CMD, PH_ADDR, PH_DUMMY, PH_DATA
  } fwr_phase_t;

  typedef enum logic [1:0] {
    C_IDLE, C_FILL, C_LOAD, C_RESP
  } fwr_ctl_t;

  function automatic fwr_phase_t fwr_after(fwr_phase_t cur, logic addr_en, logic dmy_en);
    fwr_phase_t nxt;
    nxt = PH_DATA;
    if (cur == PH_CMD && addr_en) nxt = PH_ADDR;
    else if ((cur == PH_CMD || cur == PH_ADDR) && dmy_en) nxt = PH_DUMMY;
    return nxt;
  endfunction

endpackage

// File: rtl/fwr_cfg_regs.sv
module fwr_cfg_regs
  import fwr_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [1:0]            cfg_sel,
  input  logic [FWR_CFG_DW-1:0] cfg_wdata,
  output fwr_cfg_t              cfg,
  output logic                  inval
);

  assign inval = cfg_we && ((cfg_sel == SEL_CMD) || (cfg_sel == SEL_DMY) ||
                            ((cfg_sel == SEL_CACHE) && cfg_wdata[0]));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg.win_mode  <= 1'b0;
      cfg.cmd       <= 8'h03;
      cfg.cmd_en    <= 1'b1;
      cfg.addr_mask <= ADDR_MASK_3B;
      cfg.dmy_en    <= 1'b0;
      cfg.dmy_n     <= '0;
      cfg.burst_en  <= 1'b0;
      cfg.burst_len <= '0;
    end else if (cfg_we) begin
      case (cfg_sel)
        SEL_MODE: cfg.win_mode <= cfg_wdata[0];
        SEL_CMD: begin
          cfg.cmd       <= cfg_wdata[FWR_CMD_W-1:0];
          cfg.cmd_en    <= cfg_wdata[8];
          cfg.addr_mask <= cfg_wdata[12:9];
          cfg.dmy_en    <= cfg_wdata[13];
        end
        SEL_DMY: cfg.dmy_n <= cfg_wdata[FWR_DMY_W-1:0];
        default: begin
          cfg.burst_en  <= cfg_wdata[1];
          cfg.burst_len <= cfg_wdata[2 +: FWR_BL_W];
        end
      endcase
    end
  end

endmodule

// File: rtl/fwr_spi_seq.sv
module fwr_spi_seq
  import fwr_pkg::*;
#(
  parameter int AW    = 24,
  parameter int CNT_W = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [FWR_CMD_W-1:0] cmd,
  input  logic                 cmd_en,
  input  logic                 addr_en,
  input  logic [AW-1:0]        addr,
  input  logic                 dmy_en,
  input  logic [FWR_DMY_W-1:0] dmy_n,
  input  logic [CNT_W-1:0]     nbytes,
  output logic                 spi_cs_n,
  output logic                 spi_sck,
  output logic                 spi_mosi,
  input  logic                 spi_miso,
  output logic                 byte_vld,
  output logic [7:0]           byte_dat,
  output logic                 done
);

  localparam int TX_W  = FWR_CMD_W + AW;
  localparam int BIT_W = $clog2((AW > 16) ? AW : 16);

  fwr_phase_t             ph;
  logic                   sck_q;
  logic [TX_W-1:0]        tx_q;
  logic [6:0]             rx_q;
  logic [BIT_W-1:0]       bits_q;
  logic [CNT_W-1:0]       left_q;
  logic                   addr_en_q, dmy_en_q;
  logic [FWR_DMY_W-1:0]   dmy_n_q;
  fwr_phase_t             first_ph, next_ph;

  function automatic logic [BIT_W-1:0] phase_bits(fwr_phase_t p, logic [FWR_DMY_W-1:0] dn);
    logic [BIT_W-1:0] b;
    case (p)
      PH_ADDR:  b = BIT_W'(AW - 1);
      PH_DUMMY: b = BIT_W'(dn);
      default:  b = BIT_W'(7);
    endcase
    return b;
  endfunction

  assign first_ph = cmd_en ? PH_CMD : fwr_after(PH_CMD, addr_en, dmy_en);
  assign next_ph  = fwr_after(ph, addr_en_q, dmy_en_q);

  assign spi_cs_n = (ph == PH_IDLE);
  assign spi_sck  = sck_q;
  assign spi_mosi = ((ph == PH_CMD) || (ph == PH_ADDR)) ? tx_q[TX_W-1] : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph        <= PH_IDLE;
      sck_q     <= 1'b0;
      tx_q      <= '0;
      rx_q      <= '0;
      bits_q    <= '0;
      left_q    <= '0;
      addr_en_q <= 1'b0;
      dmy_en_q  <= 1'b0;
      dmy_n_q   <= '0;
      byte_vld  <= 1'b0;
      byte_dat  <= '0;
      done      <= 1'b0;
    end else begin
      byte_vld <= 1'b0;
      done     <= 1'b0;
      if (ph == PH_IDLE) begin
        if (start) begin
          tx_q      <= cmd_en ? {cmd, addr} : {addr, {FWR_CMD_W{1'b0}}};
          addr_en_q <= addr_en;
          dmy_en_q  <= dmy_en;
          dmy_n_q   <= dmy_n;
          left_q    <= nbytes;
          sck_q     <= 1'b0;
          ph        <= first_ph;
          bits_q    <= phase_bits(first_ph, dmy_n);
        end
      end else begin
        sck_q <= ~sck_q;
        if (sck_q) begin
          tx_q <= tx_q << 1;
          rx_q <= {rx_q[5:0], spi_miso};
          if (bits_q != '0) begin
            bits_q <= bits_q - 1'b1;
          end else if (ph == PH_DATA) begin
            byte_vld <= 1'b1;
            byte_dat <= {rx_q, spi_miso};
            left_q   <= left_q - 1'b1;
            bits_q   <= BIT_W'(7);
            if (left_q == CNT_W'(1)) begin
              ph   <= PH_IDLE;
              done <= 1'b1;
            end
          end else begin
            ph     <= next_ph;
            bits_q <= phase_bits(next_ph, dmy_n_q);
          end
        end
      end
    end
  end

endmodule

// File: rtl/fwr_line_buf.sv
module fwr_line_buf #(
  parameter int AW        = 24,
  parameter int MAX_BYTES = 256,
  parameter int CNT_W     = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fill_start,
  input  logic [AW-1:0]    fill_base,
  input  logic [CNT_W-1:0] fill_len,
  input  logic             wr_en,
  input  logic [7:0]       wr_dat,
  input  logic             fill_done,
  input  logic             inval,
  input  logic [AW-1:0]    lk_addr,
  output logic             lk_hit,
  output logic [31:0]      lk_word
);

  localparam int IDX_W = $clog2(MAX_BYTES);

  logic [7:0]       mem [MAX_BYTES];
  logic [AW-1:0]    base_q;
  logic [CNT_W-1:0] len_q;
  logic [IDX_W-1:0] wr_idx;
  logic             valid_q, fill_ok;
  logic [AW-1:0]    diff;
  logic [IDX_W-1:0] rd_idx;

  assign diff    = lk_addr - base_q;
  assign rd_idx  = {diff[IDX_W-1:2], 2'b00};
  assign lk_hit  = valid_q && (lk_addr >= base_q) && (diff < AW'(len_q));

  generate
    for (genvar b = 0; b < 4; b++) begin : g_lane
      assign lk_word[8*b +: 8] = mem[rd_idx + IDX_W'(b)];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_dat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      len_q   <= '0;
      wr_idx  <= '0;
      valid_q <= 1'b0;
      fill_ok <= 1'b0;
    end else begin
      if (fill_start) begin
        base_q  <= fill_base;
        len_q   <= fill_len;
        wr_idx  <= '0;
        valid_q <= 1'b0;
        fill_ok <= 1'b1;
      end
      if (wr_en) wr_idx <= wr_idx + 1'b1;
      if (fill_done) valid_q <= fill_ok;
      if (inval) begin
        valid_q <= 1'b0;
        fill_ok <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/flash_window_reader.sv
module flash_window_reader
  import fwr_pkg::*;
#(
  parameter int AW         = 24,
  parameter int UNIT_BYTES = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [1:0]            cfg_sel,
  input  logic [FWR_CFG_DW-1:0] cfg_wdata,
  input  logic                  rd_valid,
  output logic                  rd_ready,
  input  logic [AW-1:0]         rd_addr,
  output logic                  resp_valid,
  input  logic                  resp_ready,
  output logic [31:0]           resp_data,
  output logic                  spi_cs_n,
  output logic                  spi_sck,
  output logic                  spi_mosi,
  input  logic                  spi_miso
);

  localparam int UNIT_LG   = $clog2(UNIT_BYTES);
  localparam int MAX_BYTES = (1 << FWR_BL_W) * UNIT_BYTES;
  localparam int CNT_W     = $clog2(MAX_BYTES + 1);

  fwr_cfg_t         cfg;
  logic             inval, win_mode, accept, lk_hit, fill_start;
  logic             byte_vld, seq_done;
  logic [7:0]       byte_dat;
  logic [31:0]      lk_word;
  logic [AW-1:0]    req_q, lk_addr, line_base;
  logic [CNT_W-1:0] units, line_len;
  fwr_ctl_t         cst;
  logic [31:0]      resp_q;

  fwr_cfg_regs u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg(cfg), .inval(inval)
  );

  assign win_mode   = cfg.win_mode;
  assign rd_ready   = (cst == C_IDLE) && win_mode;
  assign accept     = rd_valid && rd_ready;
  assign lk_addr    = (cst == C_IDLE) ? rd_addr : req_q;
  assign line_base  = {rd_addr[AW-1:UNIT_LG], {UNIT_LG{1'b0}}};
  assign units      = cfg.burst_en ? (CNT_W'(cfg.burst_len) + CNT_W'(1)) : CNT_W'(1);
  assign line_len   = units << UNIT_LG;
  assign fill_start = accept && !lk_hit;
  assign resp_valid = (cst == C_RESP);
  assign resp_data  = resp_q;

  fwr_line_buf #(.AW(AW), .MAX_BYTES(MAX_BYTES), .CNT_W(CNT_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .fill_start(fill_start), .fill_base(line_base),
    .fill_len(line_len), .wr_en(byte_vld), .wr_dat(byte_dat), .fill_done(seq_done),
    .inval(inval), .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_word(lk_word)
  );

  fwr_spi_seq #(.AW(AW), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(fill_start), .cmd(cfg.cmd), .cmd_en(cfg.cmd_en),
    .addr_en(cfg.addr_mask == ADDR_MASK_3B), .addr(line_base), .dmy_en(cfg.dmy_en),
    .dmy_n(cfg.dmy_n), .nbytes(line_len), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .byte_vld(byte_vld),
    .byte_dat(byte_dat), .done(seq_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cst    <= C_IDLE;
      req_q  <= '0;
      resp_q <= '0;
    end else begin
      case (cst)
        C_IDLE: if (accept) begin
          req_q <= rd_addr;
          if (lk_hit) begin
            resp_q <= lk_word;
            cst    <= C_RESP;
          end else begin
            cst <= C_FILL;
          end
        end
        C_FILL: if (seq_done) cst <= C_LOAD;
        C_LOAD: begin
          resp_q <= lk_word;
          cst    <= C_RESP;
        end
        default: if (resp_ready) cst <= C_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fwr_checker.sv
module fwr_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        rd_valid,
  input logic        rd_ready,
  input logic        resp_valid,
  input logic        resp_ready,
  input logic [31:0] resp_data,
  input logic        spi_cs_n,
  input logic        spi_sck,
  input logic        win_mode,
  input logic        lk_hit
);

  AST_MANUAL_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !win_mode |-> !rd_ready); // R2

  AST_IDLE_NO_CS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ready |-> spi_cs_n); // R3

  AST_HIT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready && lk_hit) |=> (resp_valid && spi_cs_n)); // R8

  AST_RESP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_data))); // R11

  AST_NO_ACCEPT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> !rd_ready); // R11

  AST_SCK_LOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck); // R12

endmodule

bind flash_window_reader fwr_checker u_fwr_chk (
  .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_ready(rd_ready),
  .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_data(resp_data),
  .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .win_mode(win_mode), .lk_hit(lk_hit)
);

// File: tb/flash_window_reader_test.sv
`timescale 1ns/1ps
module flash_window_reader_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [13:0] cfg_wdata = '0;
  logic        rd_valid = 1'b0;
  logic        rd_ready;
  logic [23:0] rd_addr = '0;
  logic        resp_valid;
  logic        resp_ready = 1'b1;
  logic [31:0] resp_data;
  logic        spi_cs_n, spi_sck, spi_mosi, spi_miso;

  always #4 clk = ~clk;

  flash_window_reader uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .resp_valid(resp_valid),
    .resp_ready(resp_ready), .resp_data(resp_data), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bench copy of the configured transaction format
  bit       b_cmd_en = 1, b_addr_en = 1, b_dmy_en = 0;
  bit [7:0] b_cmd = 8'h03;
  int       b_dn = 0, b_nbytes = 8;

  function automatic int hdr_bits();
    return (b_cmd_en ? 8 : 0) + (b_addr_en ? 24 : 0) + (b_dmy_en ? b_dn + 1 : 0);
  endfunction

  function automatic logic [7:0] fbyte(input logic [23:0] a);
    return a[7:0] ^ {a[3:0], a[7:4]} ^ a[15:8] ^ 8'h96;
  endfunction

  function automatic logic [31:0] exp_word(input logic [23:0] f);
    return {fbyte(f + 24'd3), fbyte(f + 24'd2), fbyte(f + 24'd1), fbyte(f)};
  endfunction

  // flash model
  int          txns = 0;
  int          rises = 0;
  logic [63:0] cap = '0;
  logic [23:0] maddr = '0;
  time         last_rise = 0, per = 0;

  always @(posedge spi_sck or negedge spi_cs_n) begin
    if (!spi_sck) begin
      txns++;
      rises = 0;
      cap = '0;
      maddr = '0;
    end else begin
      if (rises < hdr_bits()) cap = {cap[62:0], spi_mosi};
      if (b_addr_en && rises + 1 == (b_cmd_en ? 8 : 0) + 24) maddr = cap[23:0];
      if (rises == 1) per = $time - last_rise;
      last_rise = $time;
      rises++;
    end
  end

  function automatic logic miso_bit(input int r, input logic s, input logic [23:0] ma);
    int k;
    logic [7:0] v;
    k = r - hdr_bits() - (s ? 1 : 0);
    if (k < 0) return 1'b0;
    v = fbyte(ma + 24'(k / 8));
    return v[7 - (k % 8)];
  endfunction

  assign spi_miso = miso_bit(rises, spi_sck, maddr);

  // scoreboard
  logic [31:0] expq[$];
  bit          stall = 0;
  bit          hold_chk = 0;
  logic [31:0] held;
  int          cyc = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      resp_ready = stall ? (cyc % 3 == 2) : 1'b1;
      if (hold_chk) begin
        chk(resp_valid && resp_data == held && !rd_ready, "R11 held response",
            {31'd0, resp_valid, resp_data}, {32'd1, held});
        hold_chk = 0;
      end
      if (resp_valid) begin
        if (resp_ready) begin
          if (expq.size() == 0) chk(0, "R7 unexpected response", resp_data, 0);
          else begin
            logic [31:0] e;
            e = expq.pop_front();
            chk(resp_data == e, "R7 response word", resp_data, e);
          end
        end else begin
          held = resp_data;
          hold_chk = 1;
        end
      end
    end
  end

  task automatic cfg_write(input logic [1:0] sel, input logic [13:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_fmt(input logic [13:0] d);
    cfg_write(2'd1, d);
    b_cmd = d[7:0]; b_cmd_en = d[8]; b_addr_en = (d[12:9] == 4'b0111); b_dmy_en = d[13];
  endtask

  task automatic do_read(input logic [23:0] a, input logic [23:0] fstart, input bit hit, input string tag);
    int t0;
    bit acc;
    t0 = txns;
    expq.push_back(exp_word({fstart[23:2], 2'b00}));
    @(negedge clk);
    rd_valid = 1'b1; rd_addr = a;
    acc = rd_ready;
    while (!acc) begin
      @(negedge clk);
      acc = rd_ready;
    end
    @(negedge clk);
    rd_valid = 1'b0;
    if (hit) chk(resp_valid && spi_cs_n, "R8 hit answers next cycle without CS",
                 {resp_valid, spi_cs_n}, 2'b11);
    while (expq.size() != 0) @(negedge clk);
    @(negedge clk);
    chk(txns - t0 == (hit ? 0 : 1), tag, txns - t0, hit ? 0 : 1);
  endtask

  task automatic check_txn(input logic [23:0] base, input string tag);
    logic [63:0] e;
    int h;
    h = hdr_bits();
    e = '0;
    if (b_cmd_en) e = {56'd0, b_cmd};
    if (b_addr_en) e = (e << 24) | {40'd0, base};
    if (b_dmy_en) e = e << (b_dn + 1);
    chk(cap == e, tag, cap, e);
    chk(rises == h + 8 * b_nbytes, "R6 clock count of transaction", rises, h + 8 * b_nbytes);
    chk(per == 16, "R12 SCK period", per, 16);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!rd_ready && !resp_valid && spi_cs_n && !spi_sck, "R1 reset state",
        {rd_ready, resp_valid, spi_cs_n, spi_sck}, 4'b0010);
    rst_n = 1'b1;
    @(negedge clk);
    // R2: manual mode ignores requests
    rd_valid = 1'b1; rd_addr = 24'h000040;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(!rd_ready && !resp_valid && spi_cs_n, "R2 no service in manual mode",
          {rd_ready, resp_valid, spi_cs_n}, 3'b001);
    end
    rd_valid = 1'b0;
    cfg_write(2'd0, 14'd1);

    // R3 R4 default format: command 03 plus 24-bit address
    do_read(24'h000104, 24'h000104, 0, "R8 miss on empty buffer");
    check_txn(24'h000100, "R3 R4 header cmd+addr");
    do_read(24'h000100, 24'h000100, 1, "R8 hit same unit");
    do_read(24'h000103, 24'h000100, 1, "R7 unaligned offset hit");
    do_read(24'h000108, 24'h000108, 0, "R8 miss next unit");

    // R9 flush
    cfg_write(2'd3, 14'h0001);
    do_read(24'h00010C, 24'h00010C, 0, "R9 flush forces miss");
    cfg_write(2'd3, 14'h0000);
    do_read(24'h000108, 24'h000108, 1, "R9 write without flush keeps line");

    // R10 dummy register write invalidates; R5 dummy phase
    cfg_write(2'd2, 14'd5);
    b_dn = 5;
    do_read(24'h00010C, 24'h00010C, 0, "R10 dummy-count write invalidates");
    set_fmt(14'h2F0B);
    do_read(24'h00010C, 24'h00010C, 0, "R10 format write invalidates");
    check_txn(24'h000108, "R5 header with dummy clocks");

    // R3 command omitted
    set_fmt(14'h0E03);
    do_read(24'h000200, 24'h000200, 0, "R3 miss address only");
    check_txn(24'h000200, "R3 header without command");

    // R4 address omitted: line filled from flash address 0
    set_fmt(14'h0703);
    do_read(24'h000208, 24'h000000, 0, "R4 miss command only");
    check_txn(24'h000208, "R4 header without address");
    do_read(24'h00020C, 24'h000004, 1, "R4 hit in line from address 0");

    // R6 burst line of 4 units with back-pressure
    set_fmt(14'h0F03);
    cfg_write(2'd3, 14'h000E);
    b_nbytes = 32;
    do_read(24'h000400, 24'h000400, 0, "R6 burst miss");
    check_txn(24'h000400, "R6 header of burst fetch");
    stall = 1;
    for (int w = 1; w < 8; w++)
      do_read(24'h000400 + 24'(4 * w), 24'h000400 + 24'(4 * w), 1, "R6 burst line hits");
    stall = 0;
    do_read(24'h000420, 24'h000420, 0, "R6 miss past burst line");

    // R2 back to manual mode
    cfg_write(2'd0, 14'd0);
    @(negedge clk);
    chk(!rd_ready, "R2 manual mode blocks requests", rd_ready, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule